// File: doc/BRIEF.md
# Store Queue with Load Address Disambiguation

This block holds the stores a core has issued but not yet committed, in program order. Each store claims a slot when it is allocated. Its address and its value arrive later, separately and in either order. The store is written to memory only when the core commits it from the head of the queue.

A load presents its address together with the queue tail it recorded when it issued. That recorded position tells the block which stores come before the load. In the same cycle the block classifies the load into one of four outcomes:
- it must stall, because an earlier store's address is still unknown;
- it receives the value of a matching earlier store;
- it receives the producer tag of a matching earlier store whose value is not ready yet;
- it may read memory.

A misprediction flush drops every uncommitted store.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `sq_tail` is 0, `sq_full` is 0 and `wr_valid` is 0.
- R2: An allocation takes the slot whose index is the low bits of `sq_tail`, and `sq_tail` then advances by one. While `DEPTH` stores are live, `sq_full` is 1 and allocation requests are ignored, so `sq_tail` stays unchanged.
- R3: A store's address and value are written independently by slot index. A commit request is ignored while the head store lacks either its address or its value. The store stays queued and still answers loads.
- R4: An accepted commit retires the head store. In the next cycle `wr_valid` is 1 for one cycle, with that store's address and value. Stores retire oldest first.
- R5: A load compares only against stores from the head up to, but not including, the position `ld_mark` it recorded at issue. A load whose mark equals the head, or which lies outside the live range, always gets the memory outcome.
- R6: If any earlier store still has an unknown address, `ld_kind` is 2'b11 (stall), whatever else matches.
- R7: If the matching earlier store has its value, `ld_kind` is 2'b01 (forward) and `ld_data` carries that value.
- R8: If the matching earlier store lacks its value, `ld_kind` is 2'b10 (tag) and `ld_tag` carries the producer tag given at that store's allocation.
- R9: If no earlier store matches, `ld_kind` is 2'b00 (memory).
- R10: When several earlier stores match, the youngest of them decides the outcome.
- R11: A flush discards all uncommitted stores. In the next cycle `sq_tail` equals the head, and loads see no earlier stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a slot for a new store |
| alloc_src_tag | input | TW | Tag of the instruction producing the store's value |
| sq_tail | output | IW+1 | Tail position with wrap bit; its low bits are the next slot |
| sq_full | output | 1 | All slots live |
| addr_we | input | 1 | Write a store address |
| addr_idx | input | IW | Slot receiving the address |
| addr_val | input | AW | Store address |
| data_we | input | 1 | Write a store value |
| data_idx | input | IW | Slot receiving the value |
| data_val | input | DW | Store value |
| ld_valid | input | 1 | Load query present |
| ld_mark | input | IW+1 | Tail position the load recorded at issue |
| ld_addr | input | AW | Load address |
| ld_kind | output | 2 | 00 memory, 01 forward, 10 tag, 11 stall |
| ld_data | output | DW | Forwarded value |
| ld_tag | output | TW | Producer tag of the matching store |
| commit_en | input | 1 | Retire the head store |
| flush | input | 1 | Discard all uncommitted stores |
| wr_valid | output | 1 | Registered memory write strobe |
| wr_addr | output | AW | Address of the retired store |
| wr_data | output | DW | Value of the retired store |

## Verification
A corrupt head or tail pointer is visible at once in `sq_tail`. It also shows on the next load query as a wrong outcome, such as memory where a forward is expected. A stale valid flag turns a forward into a tag or a stall in the same cycle the load is presented. Wrong age ordering appears when two earlier stores match and the wrong value is forwarded. A retire fault shows one cycle after the commit request, as a wrong or missing write on `wr_addr`/`wr_data`.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    LD_MEM   = 2'b00,
    LD_FWD   = 2'b01,
    LD_TAG   = 2'b10,
    LD_STALL = 2'b11
  } ld_kind_e;
endpackage

// File: rtl/sq_slots.sv
// Per-slot storage: address, value, producer tag and two valid flags.
module sq_slots #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TW    = 6,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       new_we,
  input  logic [IW-1:0]              new_idx,
  input  logic [TW-1:0]              new_tag,
  input  logic                       a_we,
  input  logic [IW-1:0]              a_idx,
  input  logic [AW-1:0]              a_val,
  input  logic                       d_we,
  input  logic [IW-1:0]              d_idx,
  input  logic [DW-1:0]              d_val,
  output logic [DEPTH-1:0][AW-1:0]   s_addr,
  output logic [DEPTH-1:0][DW-1:0]   s_data,
  output logic [DEPTH-1:0][TW-1:0]   s_tag,
  output logic [DEPTH-1:0]           s_av,
  output logic [DEPTH-1:0]           s_dv
);
  // Payload fields need no reset; only the flags do.
  always_ff @(posedge clk) begin
    if (new_we) s_tag[new_idx] <= new_tag;
    if (a_we)   s_addr[a_idx]  <= a_val;
    if (d_we)   s_data[d_idx]  <= d_val;
  end

  // A new store clears both flags; later writes set them.
  always_ff @(posedge clk) begin
    if (rst) begin
      s_av <= '0;
      s_dv <= '0;
    end else begin
      if (new_we) begin
        s_av[new_idx] <= 1'b0;
        s_dv[new_idx] <= 1'b0;
      end
      if (a_we) s_av[a_idx] <= 1'b1;
      if (d_we) s_dv[d_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/sq_lookup.sv
// Age-ordered compare of a load against the stores ahead of it.
module sq_lookup
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TW    = 6,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic                       q_valid,
  input  logic [IW-1:0]              head_idx,
  input  logic [PW-1:0]              older_n,
  input  logic [AW-1:0]              q_addr,
  input  logic [DEPTH-1:0][AW-1:0]   s_addr,
  input  logic [DEPTH-1:0][DW-1:0]   s_data,
  input  logic [DEPTH-1:0][TW-1:0]   s_tag,
  input  logic [DEPTH-1:0]           s_av,
  input  logic [DEPTH-1:0]           s_dv,
  output ld_kind_e                   kind,
  output logic [DW-1:0]              f_data,
  output logic [TW-1:0]              f_tag
);
  logic          blocked;
  logic          hit;
  logic [IW-1:0] hit_idx;

  always_comb begin
    blocked = 1'b0;
    hit     = 1'b0;
    hit_idx = '0;
    // Walk oldest to youngest; a later match overwrites, so the youngest wins.
    for (int k = 0; k < DEPTH; k++) begin
      logic [IW-1:0] slot;
      slot = head_idx + IW'(k);
      if (PW'(k) < older_n) begin
        if (!s_av[slot]) begin
          blocked = 1'b1;
        end else if (s_addr[slot] == q_addr) begin
          hit     = 1'b1;
          hit_idx = slot;
        end
      end
    end
  end

  always_comb begin
    if (!q_valid)        kind = LD_MEM;
    else if (blocked)    kind = LD_STALL;
    else if (!hit)       kind = LD_MEM;
    else if (s_dv[hit_idx]) kind = LD_FWD;
    else                 kind = LD_TAG;
  end

  assign f_data = s_data[hit_idx];
  assign f_tag  = s_tag[hit_idx];
endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TW    = 6,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_valid,
  input  logic [TW-1:0] alloc_src_tag,
  output logic [PW-1:0] sq_tail,
  output logic          sq_full,
  input  logic          addr_we,
  input  logic [IW-1:0] addr_idx,
  input  logic [AW-1:0] addr_val,
  input  logic          data_we,
  input  logic [IW-1:0] data_idx,
  input  logic [DW-1:0] data_val,
  input  logic          ld_valid,
  input  logic [PW-1:0] ld_mark,
  input  logic [AW-1:0] ld_addr,
  output logic [1:0]    ld_kind,
  output logic [DW-1:0] ld_data,
  output logic [TW-1:0] ld_tag,
  input  logic          commit_en,
  input  logic          flush,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic [PW-1:0] head, tail, live_n, mark_off, older_n;
  logic          push, pop, head_done;
  logic [DEPTH-1:0][AW-1:0] s_addr;
  logic [DEPTH-1:0][DW-1:0] s_data;
  logic [DEPTH-1:0][TW-1:0] s_tag;
  logic [DEPTH-1:0]         s_av, s_dv;
  ld_kind_e                 kind;

  assign live_n    = tail - head;
  assign sq_full   = (live_n == PW'(DEPTH));
  assign sq_tail   = tail;
  assign head_done = s_av[head[IW-1:0]] & s_dv[head[IW-1:0]];
  assign push      = alloc_valid && !sq_full && !flush;
  assign pop       = commit_en && (live_n != '0) && head_done;

  // A mark behind the head (already retired) or past the tail sees nothing.
  assign mark_off  = ld_mark - head;
  assign older_n   = (mark_off > live_n) ? '0 : mark_off;

  sq_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u_slots (
    .clk(clk), .rst(rst),
    .new_we(push), .new_idx(tail[IW-1:0]), .new_tag(alloc_src_tag),
    .a_we(addr_we), .a_idx(addr_idx), .a_val(addr_val),
    .d_we(data_we), .d_idx(data_idx), .d_val(data_val),
    .s_addr(s_addr), .s_data(s_data), .s_tag(s_tag), .s_av(s_av), .s_dv(s_dv)
  );

  sq_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u_lookup (
    .q_valid(ld_valid), .head_idx(head[IW-1:0]), .older_n(older_n),
    .q_addr(ld_addr),
    .s_addr(s_addr), .s_data(s_data), .s_tag(s_tag), .s_av(s_av), .s_dv(s_dv),
    .kind(kind), .f_data(ld_data), .f_tag(ld_tag)
  );

  assign ld_kind = kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
    end else begin
      head <= head + PW'(pop);
      if (flush)     tail <= head + PW'(pop);
      else if (push) tail <= tail + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wr_valid <= 1'b0;
    else     wr_valid <= pop;
    if (pop) begin
      wr_addr <= s_addr[head[IW-1:0]];
      wr_data <= s_data[head[IW-1:0]];
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && sq_full && !flush) |=> (sq_tail == $past(sq_tail))); // R2
  AST_HOLD_INCOMPLETE: assert property (@(posedge clk) disable iff (rst)
    (commit_en && !head_done) |=> !wr_valid); // R3
  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (rst)
    pop |=> (wr_valid && head == PW'($past(head) + 1'b1))); // R4
  AST_NO_OLDER_MEM: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_mark == head) |-> (ld_kind == LD_MEM)); // R5
  AST_STALL_NEEDS_OLDER: assert property (@(posedge clk) disable iff (rst)
    (ld_kind == LD_STALL) |-> (older_n != '0)); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (sq_tail == head)); // R11
endmodule

// File: tb/tb_store_queue.sv
module tb_store_queue;
  localparam int DEPTH = 8, AW = 32, DW = 32, TW = 6;
  localparam int IW = $clog2(DEPTH), PW = IW + 1;
  localparam logic [1:0] K_MEM = 2'b00, K_FWD = 2'b01, K_TAG = 2'b10, K_STALL = 2'b11;

  logic clk = 0, rst = 1;
  logic alloc_valid = 0; logic [TW-1:0] alloc_src_tag = 0;
  logic [PW-1:0] sq_tail; logic sq_full;
  logic addr_we = 0; logic [IW-1:0] addr_idx = 0; logic [AW-1:0] addr_val = 0;
  logic data_we = 0; logic [IW-1:0] data_idx = 0; logic [DW-1:0] data_val = 0;
  logic ld_valid = 0; logic [PW-1:0] ld_mark = 0; logic [AW-1:0] ld_addr = 0;
  logic [1:0] ld_kind; logic [DW-1:0] ld_data; logic [TW-1:0] ld_tag;
  logic commit_en = 0, flush = 0;
  logic wr_valid; logic [AW-1:0] wr_addr; logic [DW-1:0] wr_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic alloc(logic [TW-1:0] t);
    @(negedge clk); alloc_valid = 1; alloc_src_tag = t;
    @(negedge clk); alloc_valid = 0;
  endtask

  task automatic set_addr(int i, logic [AW-1:0] a);
    @(negedge clk); addr_we = 1; addr_idx = IW'(i); addr_val = a;
    @(negedge clk); addr_we = 0;
  endtask

  task automatic set_data(int i, logic [DW-1:0] d);
    @(negedge clk); data_we = 1; data_idx = IW'(i); data_val = d;
    @(negedge clk); data_we = 0;
  endtask

  task automatic query(string req, int mark, logic [AW-1:0] a,
                       logic [1:0] ek, logic [DW-1:0] ev);
    @(negedge clk); ld_valid = 1; ld_mark = PW'(mark); ld_addr = a;
    #1;
    chk({req, " kind"}, ld_kind, ek);
    if (ek == K_FWD) chk({req, " data"}, ld_data, ev);
    if (ek == K_TAG) chk({req, " tag"}, ld_tag, ev);
    ld_valid = 0;
  endtask

  task automatic commit_exp(string req, bit ev, logic [AW-1:0] ea, logic [DW-1:0] ed);
    @(negedge clk); commit_en = 1;
    @(negedge clk); commit_en = 0;
    chk({req, " wr_valid"}, wr_valid, ev);
    if (ev) begin
      chk({req, " wr_addr"}, wr_addr, ea);
      chk({req, " wr_data"}, wr_data, ed);
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic t_reset();
    chk("R1 tail", sq_tail, 0);
    chk("R1 full", sq_full, 0);
    chk("R1 wr_valid", wr_valid, 0);
  endtask

  task automatic t_lookup();
    query("R9 empty queue", 0, 32'h100, K_MEM, 0);
    alloc(6'd5);
    chk("R2 tail after alloc", sq_tail, 1);
    query("R6 unknown addr", 1, 32'h100, K_STALL, 0);
    set_addr(0, 32'h100);
    query("R9 no match", 1, 32'h200, K_MEM, 0);
    query("R8 tag", 1, 32'h100, K_TAG, 5);
    set_data(0, 32'hAA);
    query("R7 forward", 1, 32'h100, K_FWD, 32'hAA);
    query("R5 younger store ignored", 0, 32'h100, K_MEM, 0);
  endtask

  task automatic t_youngest();
    alloc(6'd7);
    set_addr(1, 32'h100);
    query("R10 youngest tag", 2, 32'h100, K_TAG, 7);
    set_data(1, 32'hBB);
    query("R10 youngest data", 2, 32'h100, K_FWD, 32'hBB);
    query("R5 mark excludes slot1", 1, 32'h100, K_FWD, 32'hAA);
    alloc(6'd9);
    query("R6 stall beats match", 3, 32'h100, K_STALL, 0);
    set_addr(2, 32'h300);
    set_data(2, 32'hCC);
  endtask

  task automatic t_commit();
    commit_exp("R4 first retire", 1, 32'h100, 32'hAA);
    commit_exp("R4 second retire", 1, 32'h100, 32'hBB);
    query("R9 retired not compared", 3, 32'h100, K_MEM, 0);
  endtask

  task automatic t_incomplete();
    alloc(6'd11);
    chk("R2 tail index", sq_tail, 4);
    set_addr(3, 32'h400);
    commit_exp("R4 third retire", 1, 32'h300, 32'hCC);
    commit_exp("R3 incomplete head held", 0, 0, 0);
    query("R3 held store still answers", 4, 32'h400, K_TAG, 11);
  endtask

  task automatic t_flush();
    do_flush();
    chk("R11 tail to head", sq_tail, 3);
    query("R11 flushed store gone", 3, 32'h400, K_MEM, 0);
    query("R11 stale mark", 4, 32'h400, K_MEM, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) alloc(TW'(20 + i));
    chk("R2 full flag", sq_full, 1);
    chk("R2 tail at full", sq_tail, 11);
    alloc(6'd40);
    chk("R2 alloc ignored when full", sq_tail, 11);
    do_flush();
    chk("R11 full cleared", sq_full, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_lookup();
    t_youngest();
    t_commit();
    t_incomplete();
    t_flush();
    t_full();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule